// File: doc/BRIEF.md
# Page-Mode Asynchronous SRAM Controller

This block lets synchronous logic drive an external asynchronous static RAM of 256K sixteen-bit words. The host raises a request with a direction flag, a word address, write data, a two-bit byte mask and, for reads, a burst length. It holds these fields steady until a one-cycle acknowledge comes back. On the memory side the controller drives the address, a pair of chip selects of opposite polarity, write and output strobes, and two byte-lane strobes. It also drives a split data bus made of an output value, an output enable and an input value.

All strobe timing comes from nanosecond parameters and the clock period. Each nanosecond value becomes a whole number of cycles: it is divided by the clock period, rounded up, and never allowed below one. Read bursts use page mode. The upper fourteen address bits stay fixed while the low four bits step from word to word. When a burst runs past the end of a sixteen-word page, the controller moves to the next page and gives the first word there a full access time. After each read the data bus stays released for a turnaround gap before a write may drive it.

Top module: `sram_page_ctl`

## Requirements
- R1: After reset and whenever no access is running, the pins rest at mem_ce1_n=1, mem_ce2=0, mem_we_n=1, mem_oe_n=1, mem_ub_n=1, mem_lb_n=1 and mem_dq_oe=0, with ack=0 and rd_valid=0.
- R2: During an access the memory is selected by mem_ce1_n=0 and mem_ce2=1 together.
- R3: Mask bit 0 enables data bits 7:0 by driving mem_lb_n low. Mask bit 1 enables bits 15:8 by driving mem_ub_n low. A write with mask 00 changes no stored bit.
- R4: A write presents the address, data and lane strobes in its first cycle. In that same cycle mem_we_n goes low and then stays low for P = max(ceil(tWP), ceil(tDW)) cycles, with the data driven and the address held. It then waits Q = max(ceil(tWR), ceil(tWC) - P) recovery cycles. The acknowledge arrives P+Q cycles after the accepting edge, which is 2+2 cycles at the default settings.
- R5: mem_oe_n is high in every cycle in which mem_we_n is low.
- R6: The first word of a read is captured F = max(ceil(tAA), ceil(tRC), ceil(tOE)) cycles after the accepting edge, which is 4 at the default settings. It is presented with a single-cycle rd_valid.
- R7: Within a page, each following word increments address bits 3:0 by one and leaves bits 17:4 unchanged. That word is captured G = max(ceil(tAA), ceil(tRC)) cycles after the step.
- R8: After a word at low address bits 1111, the next word uses the full address plus one, so the page field advances and the highest address wraps to zero. That word waits F cycles.
- R9: A read with length field L returns L+1 words. The acknowledge pulses for exactly one cycle, in the same cycle as the last rd_valid.
- R10: mem_dq_oe is never high while mem_oe_n is low. It also stays low for at least ceil(tHZ) cycles after a read releases the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes: bit 0 low byte, bit 1 high byte |
| req_len | input | 5 | Read burst words minus one |
| ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle strobe per read word |
| rd_data | output | 16 | Captured read word |
| mem_addr | output | 18 | Memory address |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_ub_n | output | 1 | High-byte strobe, active low |
| mem_lb_n | output | 1 | Low-byte strobe, active low |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The bench's memory model returns a poison word unless the address and the output strobe have both been stable for the access times. A controller that samples one cycle early therefore gets wrong data. Bursts are aimed at page ends and at the top of the address space. A controller that keeps the page field or waits the short page time across a crossing shows up as wrong data or a wrong arrival cycle. Partial and empty byte masks catch swapped or inverted lane strobes, because an unwanted lane gets overwritten. The model also measures the width of each write pulse and the gap between the read bus being released and a write driving it. A short pulse, or a write that turns the bus around too early, is reported against its requirement.

// File: rtl/sram_page_pkg.sv
`timescale 1ns/1ps
package sram_page_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_PULSE,
        ST_WR_REC,
        ST_RD_WAIT,
        ST_RD_HZ
    } seq_state_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic ub_n;
        logic lb_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_REST = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1,
                                       oe_n: 1'b1, ub_n: 1'b1, lb_n: 1'b1,
                                       dq_oe: 1'b0};

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_page_timer.sv
`timescale 1ns/1ps
module sram_page_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_page_seq.sv
`timescale 1ns/1ps
module sram_page_seq
    import sram_page_pkg::*;
#(
    parameter int AW       = 18,
    parameter int DW       = 16,
    parameter int LW       = 5,
    parameter int PGW      = 4,
    parameter int TW       = 3,
    parameter int C_WPULSE = 2,
    parameter int C_WREC   = 2,
    parameter int C_FIRST  = 4,
    parameter int C_PAGE   = 4,
    parameter int C_HZ     = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_mask,
    input  logic [LW-1:0] req_len,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    input  logic [DW-1:0] dq_in,
    output pin_ctl_t      pins,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] dout,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          ack
);

    localparam logic [TW-1:0] LD_WPULSE = TW'(C_WPULSE - 1);
    localparam logic [TW-1:0] LD_WREC   = TW'(C_WREC - 1);
    localparam logic [TW-1:0] LD_FIRST  = TW'(C_FIRST - 1);
    localparam logic [TW-1:0] LD_PAGE   = TW'(C_PAGE - 1);
    localparam logic [TW-1:0] LD_HZ     = TW'(C_HZ - 1);
    localparam logic [PGW-1:0] PG_END   = '1;

    seq_state_e    st_q, st_d;
    pin_ctl_t      pins_q, pins_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [DW-1:0] dout_q, dout_d;
    logic [LW-1:0] left_q, left_d;
    logic          cap;
    logic          ack_d;
    logic          rd_valid_q;
    logic [DW-1:0] rd_data_q;
    logic          ack_q;

    always_comb begin
        st_d     = st_q;
        pins_d   = pins_q;
        addr_d   = addr_q;
        dout_d   = dout_q;
        left_d   = left_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        ack_d    = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req) begin
                    pins_d.ce1_n = 1'b0;
                    pins_d.ce2   = 1'b1;
                    pins_d.ub_n  = ~req_mask[1];
                    pins_d.lb_n  = ~req_mask[0];
                    addr_d       = req_addr;
                    tmr_load     = 1'b1;
                    if (req_wr) begin
                        pins_d.we_n  = 1'b0;
                        pins_d.oe_n  = 1'b1;
                        pins_d.dq_oe = 1'b1;
                        dout_d       = req_wdata;
                        tmr_val      = LD_WPULSE;
                        st_d         = ST_WR_PULSE;
                    end else begin
                        pins_d.we_n  = 1'b1;
                        pins_d.oe_n  = 1'b0;
                        pins_d.dq_oe = 1'b0;
                        left_d       = req_len;
                        tmr_val      = LD_FIRST;
                        st_d         = ST_RD_WAIT;
                    end
                end
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    pins_d.we_n = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_WREC;
                    st_d        = ST_WR_REC;
                end
            end
            ST_WR_REC: begin
                if (tmr_zero) begin
                    pins_d = PINS_REST;
                    ack_d  = 1'b1;
                    st_d   = ST_IDLE;
                end
            end
            ST_RD_WAIT: begin
                if (tmr_zero) begin
                    cap      = 1'b1;
                    tmr_load = 1'b1;
                    if (left_q == '0) begin
                        pins_d  = PINS_REST;
                        ack_d   = 1'b1;
                        tmr_val = LD_HZ;
                        st_d    = ST_RD_HZ;
                    end else begin
                        left_d  = left_q - 1'b1;
                        addr_d  = addr_q + 1'b1;
                        tmr_val = (addr_q[PGW-1:0] == PG_END) ? LD_FIRST : LD_PAGE;
                    end
                end
            end
            ST_RD_HZ: begin
                if (tmr_zero) begin
                    st_d = ST_IDLE;
                end
            end
            default: begin
                pins_d = PINS_REST;
                st_d   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            pins_q     <= PINS_REST;
            addr_q     <= '0;
            dout_q     <= '0;
            left_q     <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            ack_q      <= 1'b0;
        end else begin
            st_q       <= st_d;
            pins_q     <= pins_d;
            addr_q     <= addr_d;
            dout_q     <= dout_d;
            left_q     <= left_d;
            rd_valid_q <= cap;
            ack_q      <= ack_d;
            if (cap) begin
                rd_data_q <= dq_in;
            end
        end
    end

    assign pins     = pins_q;
    assign addr     = addr_q;
    assign dout     = dout_q;
    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign ack      = ack_q;

    AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !pins_q.we_n |-> pins_q.oe_n); // R5

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        pins_q.dq_oe |-> pins_q.oe_n); // R10

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q); // R9

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!pins_q.oe_n && !$past(pins_q.oe_n) && (addr_q != $past(addr_q)))
        |-> (addr_q == $past(addr_q) + 1'b1)); // R7

    AST_CAPTURE_UNDER_OE: assert property (@(posedge clk) disable iff (rst)
        rd_valid_q |-> !$past(pins_q.oe_n)); // R6

endmodule

// File: rtl/sram_page_ctl.sv
`timescale 1ns/1ps
module sram_page_ctl
    import sram_page_pkg::*;
#(
    parameter int AW     = 18,
    parameter int DW     = 16,
    parameter int LW     = 5,
    parameter int PGW    = 4,
    parameter int CLK_NS = 20,
    parameter int T_RC   = 70,
    parameter int T_AA   = 70,
    parameter int T_OE   = 25,
    parameter int T_WC   = 70,
    parameter int T_WP   = 40,
    parameter int T_DW   = 20,
    parameter int T_WR   = 0,
    parameter int T_HZ   = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_mask,
    input  logic [LW-1:0] req_len,
    output logic          ack,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic          mem_ub_n,
    output logic          mem_lb_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);

    localparam int C_WPULSE = imax(ns_to_cyc(T_WP, CLK_NS), ns_to_cyc(T_DW, CLK_NS));
    localparam int C_WREC   = imax(ns_to_cyc(T_WR, CLK_NS), ns_to_cyc(T_WC, CLK_NS) - C_WPULSE);
    localparam int C_PAGE   = imax(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_RC, CLK_NS));
    localparam int C_FIRST  = imax(C_PAGE, ns_to_cyc(T_OE, CLK_NS));
    localparam int C_HZ     = ns_to_cyc(T_HZ, CLK_NS);
    localparam int C_MAX    = imax(imax(C_WPULSE, C_WREC), imax(C_FIRST, C_HZ));
    localparam int TW       = $clog2(C_MAX + 1);

    pin_ctl_t      pins;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;

    sram_page_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_page_seq #(
        .AW(AW), .DW(DW), .LW(LW), .PGW(PGW), .TW(TW),
        .C_WPULSE(C_WPULSE), .C_WREC(C_WREC), .C_FIRST(C_FIRST),
        .C_PAGE(C_PAGE), .C_HZ(C_HZ)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .req_len   (req_len),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .dq_in     (mem_dq_in),
        .pins      (pins),
        .addr      (mem_addr),
        .dout      (mem_dq_out),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ack       (ack)
    );

    assign mem_ce1_n = pins.ce1_n;
    assign mem_ce2   = pins.ce2;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_ub_n  = pins.ub_n;
    assign mem_lb_n  = pins.lb_n;
    assign mem_dq_oe = pins.dq_oe;

    AST_SELECT_PAIRED: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !mem_oe_n) |-> (!mem_ce1_n && mem_ce2)); // R2

endmodule

// File: tb/sim_sram_page_ctl.sv
`timescale 1ns/1ps
module sim_sram_page_ctl;

    localparam int CLK_NS = 20;
    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int EP = mx(cyc(40), cyc(20));
    localparam int EQ = mx(cyc(0), cyc(70) - EP);
    localparam int EG = mx(cyc(70), cyc(70));
    localparam int EF = mx(EG, cyc(25));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, req_wr = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0] req_mask = '0;
    logic [4:0] req_len = '0;
    logic ack, rd_valid;
    logic [15:0] rd_data;
    logic [17:0] mem_addr;
    logic mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hBAD0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sram_page_ctl u0 (
        .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .req_len(req_len),
        .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] seed_word(input int a);
        return a[15:0] ^ 16'h5A5A;
    endfunction

    // Device model: array contents plus timing observers.
    logic [15:0] dev_mem [int];
    logic [15:0] ref_mem [int];
    logic [17:0] p_addr = '0;
    bit p_sel = 0, p_rd = 0, p_wlow = 0, p_dqoe = 0;
    int addr_age = 0, oe_age = 0, off_ns = 10000, we_cnt = 0, dstab = 0;
    logic [17:0] w_addr = '0;
    logic [15:0] w_data = '0;
    logic [1:0] w_be = '0;

    function automatic logic [15:0] dev_rd(input int a);
        return dev_mem.exists(a) ? dev_mem[a] : seed_word(a);
    endfunction
    function automatic logic [15:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : seed_word(a);
    endfunction

    always @(negedge clk) begin
        bit sel, rd_en, wlow;
        logic [15:0] d, o;
        if (!rst) begin
            sel   = !mem_ce1_n && mem_ce2;
            rd_en = sel && !mem_oe_n && mem_we_n && (!mem_ub_n || !mem_lb_n);
            wlow  = sel && !mem_we_n;
            addr_age = (mem_addr != p_addr || (sel && !p_sel)) ? 10 : addr_age + 20;
            oe_age   = rd_en ? (p_rd ? oe_age + 20 : 10) : 0;
            if (rd_en) off_ns = 0;
            else if (p_rd) off_ns = 10;
            else if (off_ns < 10000) off_ns = off_ns + 20;
            if (rd_en && addr_age + 10 >= 70 && oe_age + 10 >= 25) begin
                d = dev_rd(int'(mem_addr));
                mem_dq_in <= {mem_ub_n ? 8'h00 : d[15:8], mem_lb_n ? 8'h00 : d[7:0]};
            end else begin
                mem_dq_in <= 16'hBAD0;
            end
            if (mem_dq_oe && !p_dqoe)
                chk(!rd_en && off_ns >= 30, "R10", "bus turnaround ns", off_ns, 30);
            if (wlow) begin
                chk(mem_oe_n, "R5", "oe_n during write", mem_oe_n, 1);
                chk(mem_dq_oe, "R4", "data driven in pulse", mem_dq_oe, 1);
                if (!p_wlow) begin
                    w_addr = mem_addr; w_data = mem_dq_out;
                    w_be = {!mem_ub_n, !mem_lb_n}; we_cnt = 1; dstab = 1;
                end else begin
                    chk(mem_addr == w_addr, "R4", "address held in pulse", mem_addr, w_addr);
                    we_cnt++;
                    if (mem_dq_out != w_data) begin w_data = mem_dq_out; dstab = 1; end
                    else dstab++;
                end
            end else if (p_wlow) begin
                chk(we_cnt * 20 >= 40 && dstab * 20 >= 20, "R4", "pulse ns", we_cnt * 20, 40);
                o = dev_rd(int'(w_addr));
                dev_mem[int'(w_addr)] = {w_be[1] ? w_data[15:8] : o[15:8],
                                         w_be[0] ? w_data[7:0] : o[7:0]};
            end
            p_addr = mem_addr; p_sel = sel; p_rd = rd_en; p_wlow = wlow; p_dqoe = mem_dq_oe;
        end
    end

    task automatic chk_rest(input string what);
        chk({mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe} == 7'b1011110,
            "R1", what, {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe},
            7'b1011110);
    endtask

    task automatic run(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m, input logic [4:0] len);
        int n = 0, words = 0, exp_t;
        bit done = 0;
        logic [17:0] ea = a;
        logic [15:0] e, o;
        @(negedge clk);
        req = 1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m; req_len = len;
        exp_t = wr ? EP + EQ + 1 : EF + 1;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                chk(!mem_ce1_n && mem_ce2, "R2", "select pair", {mem_ce1_n, mem_ce2}, 2'b01);
                chk({mem_ub_n, mem_lb_n} == ~m, "R3", "lane strobes", {mem_ub_n, mem_lb_n}, ~m);
                chk(mem_we_n == !wr && mem_oe_n == wr, "R5", "strobe direction",
                    {mem_we_n, mem_oe_n}, {!wr, wr});
                chk(mem_addr == a, "R4", "start address", mem_addr, a);
            end
            if (rd_valid) begin
                e = ref_rd(int'(ea));
                chk(!wr, "R9", "rd_valid on write", 1, 0);
                chk((!m[0] || rd_data[7:0] == e[7:0]) && (!m[1] || rd_data[15:8] == e[15:8]),
                    (ea[3:0] == 4'h0 && words > 0) ? "R8" : "R7", "read word", rd_data, e);
                chk(n == exp_t, words == 0 ? "R6" : "R7", "word arrival cycle", n, exp_t);
                exp_t += (ea[3:0] == 4'hF) ? EF : EG;
                ea = ea + 1'b1;
                words++;
            end
            if (ack) begin
                done = 1;
                req = 0;
                if (!wr) chk(rd_valid, "R9", "ack with last word", rd_valid, 1);
            end
        end
        chk(done, "R9", "request completes", done, 1);
        if (wr) begin
            chk(n == exp_t, "R4", "write ack cycle", n, exp_t);
            o = ref_rd(int'(a));
            ref_mem[int'(a)] = {m[1] ? d[15:8] : o[15:8], m[0] ? d[7:0] : o[7:0]};
        end else begin
            chk(words == int'(len) + 1, "R9", "burst word count", words, int'(len) + 1);
        end
        chk_rest("pins after completion");
        @(negedge clk);
        chk(!ack && !rd_valid, "R9", "ack single cycle", {ack, rd_valid}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s;
        s = $urandom(32'd1234);
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk_rest("after reset");
        chk(!ack && !rd_valid, "R1", "host outputs after reset", {ack, rd_valid}, 0);
        // directed: full and partial lanes, empty mask
        run(1, 18'h00010, 16'hA5A5, 2'b11, 0);
        run(0, 18'h00010, 16'h0, 2'b11, 0);
        run(1, 18'h00010, 16'h1234, 2'b01, 0);
        run(1, 18'h00010, 16'h5678, 2'b10, 0);
        run(1, 18'h00010, 16'hFFFF, 2'b00, 0);
        run(0, 18'h00010, 16'h0, 2'b11, 0);
        run(0, 18'h00010, 16'h0, 2'b01, 0);
        // directed: page crossing, top wrap, whole page, long burst
        run(0, 18'h0000C, 16'h0, 2'b11, 9);
        run(0, 18'h3FFFE, 16'h0, 2'b11, 3);
        run(0, 18'h00020, 16'h0, 2'b11, 15);
        run(0, 18'h00025, 16'h0, 2'b10, 31);
        // write straight after a read
        run(0, 18'h00040, 16'h0, 2'b11, 2);
        run(1, 18'h00041, 16'hBEEF, 2'b11, 0);
        run(0, 18'h0003E, 16'h0, 2'b11, 4);
        for (int i = 0; i < 60; i++) begin
            bit w;
            logic [17:0] a;
            w = $urandom_range(0, 1) == 1;
            a = ($urandom_range(0, 3) == 0) ? 18'($urandom) : 18'h3FFC0 + 18'($urandom_range(0, 63));
            if (w) run(1, a, 16'($urandom), 2'($urandom_range(0, 3)), 0);
            else   run(0, a, 16'h0, 2'($urandom_range(1, 3)), 5'($urandom_range(0, 20)));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule